// File: doc/BRIEF.md
# Three-Wire EEPROM Master Sequencer

This block is the host end of a serial EEPROM link that uses three wires: a serial clock that the block drives, one data line that can carry data in either direction, and a busy flag. A local processor starts each transfer by writing a control word. The block then sends one byte on the data line, most significant bit first, and can add a programmable number of further clock cycles after it. Before those cycles start, the data line can either stay driven or be released.

When the line is released, the bits that the EEPROM returns during the further cycles are shifted into a receive register. If the processor also asks the block to wait for the device, the block keeps its busy flag high after the last clock. It then watches the data line until the EEPROM pulls it high to signal ready. At that point it raises a one-cycle interrupt and clears busy in the same cycle.

The serial clock is the system clock divided by a parameter. The clock idles low, and data changes only on its falling edge.

Top module: `eew_master`

## Requirements
- R1: A write (`wr_en_i` high) while idle starts a transfer. In the next cycle `busy_o` is 1, `sdata_oe_o` is 1 and `sdata_o` carries bit 7 of the written byte.
- R2: The byte is sent MSB first (bit 7 down to bit 0), one bit per serial clock. `sdata_o` changes only on a falling edge of `sclk_o` and stays stable while `sclk_o` is high. Rising edges of `sclk_o` are 2*DIV_HALF system clocks apart.
- R3: After the byte the block issues exactly `wr_cnt_i` further rising edges of `sclk_o`. A count of 0 adds none, so every transfer has 8 + count rising edges in total.
- R4: With `wr_float_i` clear, the data line stays driven after the byte. During the further cycles, and after the transfer ends, `sdata_oe_o` is 1 and `sdata_o` holds bit 0 of the byte.
- R5: With `wr_float_i` set, `sdata_oe_o` drops to 0 on the falling edge that ends bit 0. It stays 0 through the further cycles and after the transfer ends.
- R6: With `wr_float_i` set, `sdata_i` is sampled on each rising edge of `sclk_o` during the further cycles. Each sample is shifted into `rx_byte_o` from the LSB end, with earlier bits moving toward the MSB. `rx_byte_o` is cleared when a transfer starts.
- R7: With both `wr_float_i` and `wr_wait_i` set, `busy_o` stays 1 after the last clock until `sdata_i` is sampled high. Then `irq_o` is 1 for exactly one system clock, and `busy_o` is 0 in that same cycle.
- R8: When `wr_wait_i` is clear, or `wr_float_i` is clear, `irq_o` stays 0. In that case `busy_o` falls on the last falling edge of `sclk_o`.
- R9: A write while `busy_o` is 1 is ignored. The running transfer keeps its byte, count and options, and no new transfer follows it.
- R10: After reset, `sclk_o`, `sdata_oe_o`, `busy_o`, `irq_o` and `rx_byte_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Control register write strobe |
| wr_byte_i | input | 8 | Byte to send |
| wr_cnt_i | input | CNT_W | Number of further clock cycles after the byte |
| wr_float_i | input | 1 | Release the data line after the byte |
| wr_wait_i | input | 1 | Wait for EEPROM ready, then interrupt (only with float) |
| sdata_i | input | 1 | Data line as seen by the block |
| sclk_o | output | 1 | Serial clock |
| sdata_o | output | 1 | Data line output value |
| sdata_oe_o | output | 1 | Data line output enable |
| busy_o | output | 1 | Transfer in progress |
| irq_o | output | 1 | One-cycle interrupt on EEPROM ready |
| rx_byte_o | output | 8 | Bits received during the further cycles |

## Verification
The assertions assume the following about the inputs:
- `sdata_i` settles away from the system clock edge.
- The processor may write at any time, including while the block is busy.
- The EEPROM drives the line only while the block has released it.

The bench writes only between clock edges, on the falling system clock edge. Its responder changes `sdata_i` only while `sclk_o` is low. It holds the line low while waiting and raises it after a chosen delay. Stray writes during a transfer are made on purpose, so the ignore rule is exercised rather than avoided.

// File: rtl/eew_pkg.sv
package eew_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_EXTRA = 2'd2,
    ST_WAIT  = 2'd3
  } eew_state_e;
endpackage

// File: rtl/eew_tick.sv
module eew_tick #(
  parameter int DIV_HALF = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int DW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [DW-1:0] LAST = DW'(DIV_HALF - 1);

  logic [DW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  // R2
  tick_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && DIV_HALF > 1) |=> !tick_o);
endmodule

// File: rtl/eew_shifter.sv
module eew_shifter (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic [7:0] load_byte_i,
  input  logic       shift_i,
  input  logic       sample_i,
  input  logic       bit_i,
  output logic       tx_msb_o,
  output logic [7:0] rx_o
);
  logic [7:0] tx_q, rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q <= '0;
      rx_q <= '0;
    end else if (load_i) begin
      tx_q <= load_byte_i;
      rx_q <= '0;
    end else begin
      if (shift_i)  tx_q <= {tx_q[6:0], 1'b0};
      if (sample_i) rx_q <= {rx_q[6:0], bit_i};
    end
  end

  assign tx_msb_o = tx_q[7];
  assign rx_o     = rx_q;

  // R6
  rx_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_i && !load_i) |=> (rx_o[0] == $past(bit_i)));
endmodule

// File: rtl/eew_master.sv
module eew_master
  import eew_pkg::*;
#(
  parameter int DIV_HALF = 2,
  parameter int CNT_W    = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [7:0]       wr_byte_i,
  input  logic [CNT_W-1:0] wr_cnt_i,
  input  logic             wr_float_i,
  input  logic             wr_wait_i,
  input  logic             sdata_i,
  output logic             sclk_o,
  output logic             sdata_o,
  output logic             sdata_oe_o,
  output logic             busy_o,
  output logic             irq_o,
  output logic [7:0]       rx_byte_o
);
  eew_state_e state_q, state_d;
  logic             sclk_q, oe_q, irq_q, float_q, wait_q;
  logic [2:0]       bit_q;
  logic [CNT_W-1:0] ext_q, cnt_q;
  logic             start, run, tick, rise, fall, last_bit, last_ext, tx_msb;
  eew_state_e       end_state;

  assign start    = wr_en_i && (state_q == ST_IDLE);
  assign run      = (state_q == ST_SHIFT) || (state_q == ST_EXTRA);
  assign rise     = tick && !sclk_q;
  assign fall     = tick && sclk_q;
  assign last_bit = fall && (state_q == ST_SHIFT) && (bit_q == 3'd7);
  assign last_ext = fall && (state_q == ST_EXTRA) && (ext_q == CNT_W'(cnt_q - 1'b1));
  assign end_state = (float_q && wait_q) ? ST_WAIT : ST_IDLE;

  eew_tick #(.DIV_HALF(DIV_HALF)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run),
    .tick_o(tick)
  );

  eew_shifter u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (start),
    .load_byte_i(wr_byte_i),
    .shift_i    (fall && (state_q == ST_SHIFT) && (bit_q != 3'd7)),
    .sample_i   (rise && (state_q == ST_EXTRA) && float_q),
    .bit_i      (sdata_i),
    .tx_msb_o   (tx_msb),
    .rx_o       (rx_byte_o)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start)    state_d = ST_SHIFT;
      ST_SHIFT: if (last_bit) state_d = (cnt_q != '0) ? ST_EXTRA : end_state;
      ST_EXTRA: if (last_ext) state_d = end_state;
      ST_WAIT:  if (sdata_i)  state_d = ST_IDLE;
      default:                state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sclk_q  <= 1'b0;
      oe_q    <= 1'b0;
      irq_q   <= 1'b0;
      float_q <= 1'b0;
      wait_q  <= 1'b0;
      bit_q   <= '0;
      ext_q   <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      irq_q   <= (state_q == ST_WAIT) && sdata_i;
      if (start) begin
        sclk_q  <= 1'b0;
        oe_q    <= 1'b1;
        float_q <= wr_float_i;
        wait_q  <= wr_wait_i;
        cnt_q   <= wr_cnt_i;
        bit_q   <= '0;
        ext_q   <= '0;
      end else begin
        if (tick) sclk_q <= !sclk_q;
        if (fall && state_q == ST_SHIFT && bit_q != 3'd7) bit_q <= bit_q + 1'b1;
        if (fall && state_q == ST_EXTRA) ext_q <= ext_q + 1'b1;
        if (last_bit && float_q) oe_q <= 1'b0;
      end
    end
  end

  assign sclk_o     = sclk_q;
  assign sdata_oe_o = oe_q;
  assign sdata_o    = oe_q & tx_msb;
  assign busy_o     = (state_q != ST_IDLE);
  assign irq_o      = irq_q;

  // R7
  irq_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
  // R7
  irq_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (!busy_o && $past(busy_o)));
  // R8
  irq_cfg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (float_q && wait_q));
  // R2
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o && $past(sclk_o)) |-> $stable(sdata_o));
  // R5
  wait_float_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT) |-> !sdata_oe_o);
  // R9
  busy_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && wr_en_i) |=> ($stable(cnt_q) && $stable(float_q) && $stable(wait_q)));
  // R10
  idle_clk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !sclk_o);
endmodule

// File: tb/tb_eew_master.sv
module tb_eew_master;
  localparam int DIV_HALF = 2;
  localparam int CNT_W    = 4;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic wr_en = 1'b0, wr_float = 1'b0, wr_wait = 1'b0, sdata_i = 1'b0;
  logic [7:0] wr_byte = '0;
  logic [CNT_W-1:0] wr_cnt = '0;
  logic sclk_o, sdata_o, sdata_oe_o, busy_o, irq_o;
  logic [7:0] rx_byte_o;

  int checks = 0, errors = 0;

  always #2.5 clk = !clk;

  eew_master #(.DIV_HALF(DIV_HALF), .CNT_W(CNT_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_byte_i(wr_byte),
    .wr_cnt_i(wr_cnt), .wr_float_i(wr_float), .wr_wait_i(wr_wait),
    .sdata_i(sdata_i), .sclk_o(sclk_o), .sdata_o(sdata_o),
    .sdata_oe_o(sdata_oe_o), .busy_o(busy_o), .irq_o(irq_o), .rx_byte_o(rx_byte_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rx(input int c, input logic [15:0] pat);
    logic [7:0] r = '0;
    for (int k = 0; k < c; k++) r = {r[6:0], pat[k % 16]};
    return r;
  endfunction

  task automatic run_xfer(input logic [7:0] b, input int c, input bit fl, input bit wt,
                          input logic [15:0] pat, input int rdy, input bit poke);
    int rises = 0, since = 0, t = 0, wcnt = 0;
    int bad_main = 0, bad_ext = 0, bad_per = 0, bad_hold = 0, irqs = 0;
    bit poked = 0, prev, hold = 0, irq_ok = 1;
    @(negedge clk);
    wr_en = 1'b1; wr_byte = b; wr_cnt = CNT_W'(c); wr_float = fl; wr_wait = wt;
    @(negedge clk);
    wr_en = 1'b0;
    // R1
    chk(busy_o && sdata_oe_o && sdata_o == b[7], "R1", "start state",
        {busy_o, sdata_oe_o, sdata_o}, {1'b1, 1'b1, b[7]});
    prev = sclk_o;
    while (busy_o && t < 4000) begin
      if (!sclk_o) begin
        if (rises >= 8 && rises < 8 + c) sdata_i = pat[(rises - 8) % 16];
        else if (rises >= 8 + c && fl && wt) begin sdata_i = (wcnt >= rdy); wcnt++; end
        else sdata_i = 1'b0;
      end
      if (poke && rises == 3 && !poked) begin
        wr_en = 1'b1; wr_byte = ~b; wr_cnt = CNT_W'(c + 1); wr_float = !fl; poked = 1;
      end else wr_en = 1'b0;
      @(negedge clk);
      t++; since++;
      if (irq_o) begin
        irqs++;
        if (busy_o || !sdata_i) irq_ok = 0;
      end
      if (sclk_o && !prev) begin
        if (rises > 0 && since != 2 * DIV_HALF) bad_per++;
        if (rises < 8) begin
          if (!(sdata_oe_o && sdata_o == b[7 - rises])) bad_main++;
        end else if (fl) begin
          if (sdata_oe_o) bad_ext++;
        end else if (!(sdata_oe_o && sdata_o == b[0])) bad_ext++;
        hold = sdata_o; rises++; since = 0;
      end else if (sclk_o && sdata_o != hold) bad_hold++;
      prev = sclk_o;
    end
    wr_en = 1'b0;
    sdata_i = 1'b0;
    chk(t < 4000, "R7", "watchdog expired", t, 4000);
    // R3
    chk(rises == 8 + c, "R3", "rising edge count", rises, 8 + c);
    // R2
    chk(bad_main == 0 && bad_hold == 0, "R2", "byte bits MSB first/stable", bad_main + bad_hold, 0);
    chk(bad_per == 0, "R2", "clock period", bad_per, 0);
    if (fl) begin
      // R5
      chk(bad_ext == 0 && !sdata_oe_o, "R5", "line released", bad_ext, 0);
      // R6
      chk(rx_byte_o == exp_rx(c, pat), "R6", "receive byte", rx_byte_o, exp_rx(c, pat));
    end else begin
      // R4
      chk(bad_ext == 0 && sdata_oe_o && sdata_o == b[0], "R4", "line held", bad_ext, 0);
    end
    if (fl && wt) begin
      // R7
      chk(irqs == 1 && irq_ok && wcnt > rdy, "R7", "ready interrupt", irqs, 1);
      @(negedge clk);
      chk(!irq_o, "R7", "interrupt width", irq_o, 0);
    end else begin
      @(negedge clk);
      // R8
      chk(irqs == 0 && !irq_o, "R8", "no interrupt", irqs, 0);
    end
    if (poke) begin
      repeat (12) begin
        @(negedge clk);
        if (busy_o || sclk_o) irqs += 100;
      end
      // R9
      chk(irqs < 100 && rises == 8 + c, "R9", "write while busy ignored", irqs, 0);
    end
  endtask

  initial begin
    void'($urandom(32'h1a2b3c));
    repeat (3) @(negedge clk);
    // R10
    chk(!sclk_o && !sdata_oe_o && !busy_o && !irq_o && rx_byte_o == 0, "R10", "reset outputs",
        {sclk_o, sdata_oe_o, busy_o, irq_o}, 0);
    rst_ni = 1'b1;
    run_xfer(8'hA5, 0, 0, 0, 16'h0000, 0, 0);
    run_xfer(8'h3C, 3, 0, 0, 16'hFFFF, 0, 0);
    run_xfer(8'h96, 5, 1, 0, 16'b1011_0110_0101_1001, 0, 0);
    run_xfer(8'hC3, 10, 1, 1, 16'hB4E1, 7, 0);
    run_xfer(8'h5A, 0, 1, 1, 16'h0000, 0, 0);
    run_xfer(8'hF0, 2, 0, 1, 16'h0003, 3, 0);
    run_xfer(8'h81, 15, 1, 0, 16'h7F3D, 0, 0);
    run_xfer(8'h6E, 4, 0, 0, 16'h0000, 0, 1);
    run_xfer(8'h19, 6, 1, 1, 16'h2C5A, 2, 1);
    for (int i = 0; i < 30; i++) begin
      logic [31:0] r = $urandom;
      run_xfer(r[7:0], int'(r[11:8]), r[12], r[13], r[29:14], int'(r[17:15]), r[30]);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule